// File: doc/BRIEF.md
# Interlocked Two-Wire Byte Handshake Link

This block moves one byte at a time from a sending unit to a receiving unit. The two units are independent and share no transfer timing. They cooperate only through two handshake wires, a forward "valid" line driven by the sender and a backward line driven by the receiver, together with a parallel data bus. Every transfer is a full four-phase interlocked exchange, so it completes only when both sides take an active part. The meaning of the backward line depends on who starts the exchange. When the sender starts, the line acts as an acknowledge. When the receiver starts, the line acts as a request for data.

The sender side takes a byte and a one-cycle start request. The receiver side has a "take" input that says it is willing to receive, and it reports each received byte with a one-cycle pulse. Each side runs a stall watchdog while it waits for its partner. If the partner stays silent for `TIMEOUT` cycles, that side raises a sticky error flag and returns to idle instead of finishing quietly. Both sides run on one clock, and every handshake line comes from a state register.

Sender states: `SRC_IDLE`, `SRC_ARMED` (receiver-started mode, request taken, waiting for the ready line), `SRC_SETUP` (bus driven, valid still low), `SRC_VALID` (valid high, waiting for the partner), `SRC_RELEASE` (sender-started mode, valid dropped, waiting for the acknowledge to fall). Sender transitions: IDLE→SETUP on start in sender-started mode. IDLE→ARMED on start in receiver-started mode. ARMED→SETUP when the backward line is high. SETUP→VALID always. VALID→RELEASE when the acknowledge rises (sender-started mode). VALID→IDLE when the ready line falls (receiver-started mode). RELEASE→IDLE when the acknowledge falls. ARMED, VALID and RELEASE each go to IDLE with an error when the watchdog expires.

Receiver states: `DST_IDLE`, `DST_READY` (ready line high, waiting for valid), `DST_ACK` (acknowledge high, waiting for valid to fall), `DST_DRAIN` (ready dropped after capture, waiting for valid to fall). Receiver transitions: IDLE→ACK when valid is seen with take high in sender-started mode (this captures the byte). IDLE→READY on take in receiver-started mode. READY→DRAIN when valid is seen (this captures the byte). ACK→IDLE and DRAIN→IDLE when valid falls. READY, ACK and DRAIN each go to IDLE with an error when the watchdog expires.

Top module: `hs_xfer_link`

## Requirements
- R1: While reset is held, and in the first cycle after it: link_valid, link_back, rx_pulse, src_busy, src_err and dst_err are 0, and link_bus and rx_data are all zero.
- R2: With mode 0 (sender-started), a start pulse in idle puts the byte on link_bus in the next cycle while link_valid is still low. link_valid rises one cycle later. link_back (acknowledge) rises in the cycle after the receiver sees valid with take high. link_valid falls and the bus goes to zero one cycle after that. link_back falls one cycle after valid falls. The sender is idle one cycle later.
- R3: With mode 1 (receiver-started), take high in receiver idle raises link_back (ready) in the next cycle. A pending start then makes the sender drive the bus, and one cycle later link_valid. The receiver drops link_back one cycle after it sees valid. The sender drops link_valid and zeroes the bus one cycle after it sees ready fall.
- R4: In the cycle after the capture step (receiver sees valid in the capturing state), rx_pulse is high for exactly one cycle and rx_data holds the byte that was on the bus.
- R5: link_bus is all zero whenever the sender is idle or releasing. It carries data only from the setup cycle until valid falls.
- R6: A start request while the sender is busy is ignored. The byte being sent is not replaced and no extra transfer follows.
- R7: The mode input is sampled only in idle. A change of mode during a transfer does not alter that transfer's sequence.
- R8: If the sender waits TIMEOUT cycles in ARMED, VALID or RELEASE without the partner's answer, src_err is set, the sender returns to idle and link_valid drops.
- R9: If the receiver waits TIMEOUT cycles in READY, ACK or DRAIN without the partner's answer, dst_err is set, the receiver returns to idle and link_back drops.
- R10: src_err and dst_err stay set until reset, and transfers still complete while they are set.
- R11: In mode 0 with take low, the receiver never captures: no rx_pulse occurs.
- R12: If the partner's answer arrives in the same cycle that the watchdog expires, the answer wins. The transfer proceeds and no error is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 1 | 0 = sender-started, 1 = receiver-started; sampled in idle |
| src_start | input | 1 | One-cycle request to send src_data |
| src_data | input | DATA_W | Byte to send, taken with src_start |
| dst_take | input | 1 | Receiver is willing to receive |
| link_valid | output | 1 | Forward handshake line from the sender |
| link_back | output | 1 | Backward line: acknowledge (mode 0) or ready (mode 1) |
| link_bus | output | DATA_W | Data bus, all zero when not driven |
| src_busy | output | 1 | Sender is not idle |
| src_err | output | 1 | Sticky sender stall flag |
| dst_err | output | 1 | Sticky receiver stall flag |
| rx_pulse | output | 1 | One-cycle received strobe |
| rx_data | output | DATA_W | Last captured byte |

## Verification
The watchdog expiry and the partner's answer can fall in the same cycle. The test provokes this in sender-started mode by holding take low after a start, then raising it so that the receiver captures on exactly the sender's last waiting cycle. The acknowledge then reaches the sender together with the expiry. The run passes only if the transfer completes with one received pulse and src_err stays clear. A second collision, a mode change or a new start arriving while a transfer is in flight, is judged by the bytes received and by the cycle-by-cycle sequence of the lines.

// File: rtl/hs_xfer_pkg.sv
package hs_xfer_pkg;

    typedef enum logic {
        INIT_SOURCE = 1'b0,
        INIT_DEST   = 1'b1
    } init_mode_t;

    typedef enum logic [2:0] {
        SRC_IDLE,
        SRC_ARMED,
        SRC_SETUP,
        SRC_VALID,
        SRC_RELEASE
    } src_state_t;

    typedef enum logic [1:0] {
        DST_IDLE,
        DST_READY,
        DST_ACK,
        DST_DRAIN
    } dst_state_t;

endpackage

// File: rtl/hs_stall_timer.sv
module hs_stall_timer #(
    parameter int LIMIT = 16,
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hs_src_side.sv
module hs_src_side
    import hs_xfer_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int TIMEOUT = 16,
    parameter int CNT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              back_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] bus_o,
    output logic              busy_o,
    output logic              err_o
);
    src_state_t        state_q, state_d;
    init_mode_t        mode_q;
    logic [DATA_W-1:0] data_q;
    logic              err_q;
    logic              set_err;
    logic              waiting;
    logic              expired;
    logic              answered;

    assign waiting  = (state_q == SRC_ARMED) || (state_q == SRC_VALID) ||
                      (state_q == SRC_RELEASE);
    assign answered = (mode_q == INIT_SOURCE) ? back_i : !back_i;

    hs_stall_timer #(.LIMIT(TIMEOUT), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   ((state_d != state_q) || !waiting),
        .expired (expired)
    );

    always_comb begin
        state_d = state_q;
        set_err = 1'b0;
        unique case (state_q)
            SRC_IDLE: begin
                if (start_i) begin
                    state_d = (init_mode_t'(mode_i) == INIT_DEST) ? SRC_ARMED : SRC_SETUP;
                end
            end
            SRC_ARMED: begin
                if (back_i) begin
                    state_d = SRC_SETUP;
                end else if (expired) begin
                    state_d = SRC_IDLE;
                    set_err = 1'b1;
                end
            end
            SRC_SETUP: state_d = SRC_VALID;
            SRC_VALID: begin
                if (answered) begin
                    state_d = (mode_q == INIT_SOURCE) ? SRC_RELEASE : SRC_IDLE;
                end else if (expired) begin
                    state_d = SRC_IDLE;
                    set_err = 1'b1;
                end
            end
            SRC_RELEASE: begin
                if (!back_i) begin
                    state_d = SRC_IDLE;
                end else if (expired) begin
                    state_d = SRC_IDLE;
                    set_err = 1'b1;
                end
            end
            default: state_d = SRC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_IDLE;
            mode_q  <= INIT_SOURCE;
            data_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == SRC_IDLE && start_i) begin
                mode_q <= init_mode_t'(mode_i);
                data_q <= data_i;
            end
            if (set_err) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        valid_o = 1'b0;
        bus_o   = '0;
        unique case (state_q)
            SRC_SETUP: bus_o = data_q;
            SRC_VALID: begin
                valid_o = 1'b1;
                bus_o   = data_q;
            end
            default: ;
        endcase
        busy_o = (state_q != SRC_IDLE);
        err_o  = err_q;
    end
endmodule

// File: rtl/hs_dst_side.sv
module hs_dst_side
    import hs_xfer_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int TIMEOUT = 16,
    parameter int CNT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              take_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic              back_o,
    output logic              rx_pulse_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              err_o
);
    dst_state_t        state_q, state_d;
    logic              capture;
    logic              set_err;
    logic              waiting;
    logic              expired;
    logic              err_q;
    logic              rx_pulse_q;
    logic [DATA_W-1:0] rx_data_q;

    assign waiting = (state_q != DST_IDLE);

    hs_stall_timer #(.LIMIT(TIMEOUT), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   ((state_d != state_q) || !waiting),
        .expired (expired)
    );

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        set_err = 1'b0;
        unique case (state_q)
            DST_IDLE: begin
                if (init_mode_t'(mode_i) == INIT_SOURCE) begin
                    if (take_i && valid_i) begin
                        state_d = DST_ACK;
                        capture = 1'b1;
                    end
                end else if (take_i) begin
                    state_d = DST_READY;
                end
            end
            DST_READY: begin
                if (valid_i) begin
                    state_d = DST_DRAIN;
                    capture = 1'b1;
                end else if (expired) begin
                    state_d = DST_IDLE;
                    set_err = 1'b1;
                end
            end
            DST_ACK, DST_DRAIN: begin
                if (!valid_i) begin
                    state_d = DST_IDLE;
                end else if (expired) begin
                    state_d = DST_IDLE;
                    set_err = 1'b1;
                end
            end
            default: state_d = DST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= DST_IDLE;
            err_q      <= 1'b0;
            rx_pulse_q <= 1'b0;
            rx_data_q  <= '0;
        end else begin
            state_q    <= state_d;
            rx_pulse_q <= capture;
            if (capture) begin
                rx_data_q <= bus_i;
            end
            if (set_err) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        back_o     = (state_q == DST_READY) || (state_q == DST_ACK);
        rx_pulse_o = rx_pulse_q;
        rx_data_o  = rx_data_q;
        err_o      = err_q;
    end
endmodule

// File: rtl/hs_xfer_link.sv
module hs_xfer_link #(
    parameter int DATA_W  = 8,
    parameter int TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic              src_start,
    input  logic [DATA_W-1:0] src_data,
    input  logic              dst_take,
    output logic              link_valid,
    output logic              link_back,
    output logic [DATA_W-1:0] link_bus,
    output logic              src_busy,
    output logic              src_err,
    output logic              dst_err,
    output logic              rx_pulse,
    output logic [DATA_W-1:0] rx_data
);
    localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

    hs_src_side #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode),
        .start_i (src_start),
        .data_i  (src_data),
        .back_i  (link_back),
        .valid_o (link_valid),
        .bus_o   (link_bus),
        .busy_o  (src_busy),
        .err_o   (src_err)
    );

    hs_dst_side #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_dst (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .take_i     (dst_take),
        .valid_i    (link_valid),
        .bus_i      (link_bus),
        .back_o     (link_back),
        .rx_pulse_o (rx_pulse),
        .rx_data_o  (rx_data),
        .err_o      (dst_err)
    );
endmodule

// File: rtl/hs_xfer_link_chk.sv
module hs_xfer_link_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              link_valid,
    input logic              link_back,
    input logic [DATA_W-1:0] link_bus,
    input logic              src_busy,
    input logic              src_err,
    input logic              dst_err,
    input logic              rx_pulse
);
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !src_busy |-> (link_bus == '0)); // R5
    AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid |-> src_busy); // R2
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pulse |=> !rx_pulse); // R4
    AST_PULSE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pulse |-> $past(link_valid)); // R4
    AST_SRC_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        src_err |=> src_err); // R10
    AST_DST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        dst_err |=> dst_err); // R10
    AST_SRC_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_err) |-> (!src_busy && !link_valid)); // R8
    AST_DST_ERR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dst_err) |-> !link_back); // R9
endmodule

bind hs_xfer_link hs_xfer_link_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_valid (link_valid),
    .link_back  (link_back),
    .link_bus   (link_bus),
    .src_busy   (src_busy),
    .src_err    (src_err),
    .dst_err    (dst_err),
    .rx_pulse   (rx_pulse)
);

// File: tb/hs_xfer_link_test.sv
module hs_xfer_link_test;
    localparam int DW = 8;
    localparam int TO = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode = 1'b0;
    logic          start = 1'b0;
    logic          take = 1'b0;
    logic [DW-1:0] data = '0;

    logic          link_valid, link_back, src_busy, src_err, dst_err, rx_pulse;
    logic [DW-1:0] link_bus, rx_data;

    always #4 clk = ~clk;

    hs_xfer_link #(.DATA_W(DW), .TIMEOUT(TO)) uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .src_start(start),
        .src_data(data), .dst_take(take), .link_valid(link_valid),
        .link_back(link_back), .link_bus(link_bus), .src_busy(src_busy),
        .src_err(src_err), .dst_err(dst_err), .rx_pulse(rx_pulse),
        .rx_data(rx_data)
    );

    int    checks = 0;
    int    errors = 0;
    int    pulses = 0;
    int    cyc = 0;
    string tag = "R1";

    // behavioural reference: phases as integers
    // sender: 0 idle, 1 waiting ready, 2 bus out, 3 valid out, 4 releasing
    // receiver: 0 idle, 1 ready out, 2 ack out, 3 draining
    int sp = 0, sm = 0, sc = 0, serr = 0;
    int dp = 0, dc = 0, derr = 0, rxp = 0;
    int sd = 0, rxd = 0;
    int ov, ob, obus;

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            sp = 0; sm = 0; sc = 0; serr = 0; sd = 0;
            dp = 0; dc = 0; derr = 0; rxp = 0; rxd = 0;
        end else begin
            ov   = (sp == 3);
            ob   = (dp == 1 || dp == 2);
            obus = (sp == 2 || sp == 3) ? sd : 0;
            // sender
            if (sp == 0) begin
                if (start) begin
                    sm = mode; sd = data; sp = mode ? 1 : 2; sc = 0;
                end
            end else if (sp == 2) begin
                sp = 3; sc = 0;
            end else begin
                if ((sp == 1 && ob) || (sp == 3 && sm == 0 && ob) ||
                    (sp == 3 && sm == 1 && !ob) || (sp == 4 && !ob)) begin
                    if (sp == 1) sp = 2;
                    else if (sp == 3 && sm == 0) sp = 4;
                    else sp = 0;
                    sc = 0;
                end else if (sc == TO - 1) begin
                    sp = 0; sc = 0; serr = 1;
                end else begin
                    sc++;
                end
            end
            // receiver
            rxp = 0;
            if (dp == 0) begin
                dc = 0;
                if (mode == 1'b0) begin
                    if (take && ov) begin
                        rxp = 1; rxd = obus; dp = 2;
                    end
                end else if (take) begin
                    dp = 1;
                end
            end else if (dp == 1 && ov) begin
                rxp = 1; rxd = obus; dp = 3; dc = 0;
            end else if (dp != 1 && !ov) begin
                dp = 0; dc = 0;
            end else if (dc == TO - 1) begin
                dp = 0; dc = 0; derr = 1;
            end else begin
                dc++;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(tag, int'(link_valid), (sp == 3) ? 1 : 0, "link_valid");
            check(tag, int'(link_back), (dp == 1 || dp == 2) ? 1 : 0, "link_back");
            check(tag, int'(link_bus), (sp == 2 || sp == 3) ? sd : 0, "link_bus");
            check(tag, int'(src_busy), (sp != 0) ? 1 : 0, "src_busy");
            check(tag, int'(src_err), serr, "src_err");
            check(tag, int'(dst_err), derr, "dst_err");
            check(tag, int'(rx_pulse), rxp, "rx_pulse");
            check(tag, int'(rx_data), rxd, "rx_data");
            if (rx_pulse) pulses++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual %0d expected below 20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic [DW-1:0] d);
        @(negedge clk);
        data  = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        take  = 1'b0;
        mode  = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    int p0;

    initial begin
        // R1 reset state
        idle(3);
        check("R1", int'(link_valid) + int'(link_back) + int'(rx_pulse), 0, "lines in reset");
        check("R1", int'(src_busy) + int'(src_err) + int'(dst_err), 0, "flags in reset");
        check("R1", int'(link_bus) + int'(rx_data), 0, "bus and rx_data in reset");
        rst_n = 1'b1;
        idle(2);

        // R2 and R4: sender-started transfer
        tag = "R2"; mode = 1'b0; take = 1'b1; p0 = pulses;
        send(8'hA5);
        idle(10);
        check("R4", int'(rx_data), 'hA5, "received byte");
        check("R4", pulses - p0, 1, "pulse count");

        // R6: start held while busy
        tag = "R6"; p0 = pulses;
        @(negedge clk); data = 8'h3C; start = 1'b1;
        @(negedge clk); data = 8'hFF;
        @(negedge clk);
        @(negedge clk); start = 1'b0;
        idle(10);
        check("R6", int'(rx_data), 'h3C, "byte kept while busy");
        check("R6", pulses - p0, 1, "no extra transfer");

        // R3: receiver-started transfer
        tag = "R3"; mode = 1'b1; take = 1'b0; p0 = pulses;
        @(negedge clk); take = 1'b1;
        @(negedge clk); take = 1'b0;
        send(8'h5A);
        idle(10);
        check("R3", int'(rx_data), 'h5A, "received byte");
        check("R3", int'(dst_err), 0, "no receiver error");

        // R7: mode flipped mid-transfer
        tag = "R7"; mode = 1'b1; p0 = pulses;
        @(negedge clk); take = 1'b1;
        @(negedge clk); take = 1'b0;
        send(8'h96);
        mode = 1'b0;
        idle(12);
        check("R7", int'(rx_data), 'h96, "received byte");
        check("R7", int'(src_err), 0, "sequence unchanged");

        // R8 and R11: receiver never takes
        tag = "R8"; mode = 1'b0; take = 1'b0; p0 = pulses;
        send(8'h11);
        idle(TO + 6);
        check("R8", int'(src_err), 1, "sender error");
        check("R8", int'(src_busy) + int'(link_valid), 0, "sender idle");
        check("R11", pulses - p0, 0, "no capture with take low");

        do_reset();
        // R9: receiver asks, sender silent
        tag = "R9"; mode = 1'b1;
        @(negedge clk); take = 1'b1;
        @(negedge clk); take = 1'b0;
        idle(TO + 4);
        check("R9", int'(dst_err), 1, "receiver error");
        check("R9", int'(link_back), 0, "ready dropped");

        // R10: error sticky, link still works
        tag = "R10"; mode = 1'b0; take = 1'b1; p0 = pulses;
        send(8'h7E);
        idle(10);
        check("R10", int'(dst_err), 1, "error kept");
        check("R10", int'(rx_data), 'h7E, "transfer after error");

        do_reset();
        // R12: answer in the expiry cycle
        tag = "R12"; mode = 1'b0; take = 1'b0; p0 = pulses;
        @(negedge clk); data = 8'hE7; start = 1'b1;
        @(negedge clk); start = 1'b0;
        idle(15);
        take = 1'b1;
        idle(10);
        check("R12", int'(src_err), 0, "answer beats timeout");
        check("R12", int'(rx_data), 'hE7, "received byte");
        check("R12", pulses - p0, 1, "one pulse");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule